// File: doc/BRIEF.md
# Processor Interrupt Level Prioritizer

This block decides whether the processor core should see a hardware interrupt, and which trap it would take. It merges sixteen level-sensitive external request lines with a software interrupt word. Two timer-match bits in that word are not treated as levels of their own; they raise level 14 instead. Every cycle it looks for the highest pending level that lies strictly above the current processor interrupt level.

When interrupts are enabled and such a level exists, the block registers a trap type. That trap type is a fixed base ORed with the level number, and the block raises its request flag. Two conditions leave the held request unchanged: a trap already being handled at a nonzero trap level with a numerically larger trap type, and globally disabled interrupts. When nothing at all is pending, the request is withdrawn and the trap type returns to zero.

A separate one-cycle wake pulse marks each rising edge on any external line, so that a halted core resumes. The outputs are registered, so a change on the inputs is visible at the outputs one clock later.

Top module: `pil_prioritizer`

## Requirements
- R1: The software word `soft_int` has bit 0 as the tick-match flag and bit 16 as the stick-match flag. Bit k, for k from 1 to 15, requests level k directly, in the same way as external line `ext_lvl[k]`.
- R2: When tick-match or stick-match (or both) is set, level 14 is pending. Neither flag makes any other level pending.
- R3: When no level is pending from any source, `irq_req` is 0 and `irq_tt` is 0 one clock later.
- R4: With `int_en` high, the highest pending level L that satisfies L > `cur_pil` is the winner. One clock later, `irq_tt` = 0x40 | L and `irq_req` = 1. Level 0 never wins.
- R5: When `trap_lvl` is nonzero and `trap_tt_cur` is greater than the candidate trap type, `irq_tt` and `irq_req` keep their previous values.
- R6: When some level is pending but none lies above `cur_pil`, or when the candidate equals the held trap type, `irq_tt` and `irq_req` keep their previous values.
- R7: With `int_en` low and some level pending, `irq_tt` and `irq_req` keep their previous values.
- R8: `wake` is 1 for one clock after a clock edge at which some `ext_lvl` bit went from 0 to 1. A falling line, or any change on `soft_int`, gives no wake.
- R9: While `rst_n` is low, `irq_req`, `irq_tt` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_lvl | input | 16 | External level request lines, one per level |
| soft_int | input | 17 | Software interrupt word: bit 0 tick-match, bit 16 stick-match, bits 15..1 levels |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| trap_tt_cur | input | 9 | Trap type recorded at the current trap level |
| irq_req | output | 1 | Hardware interrupt request to the core |
| irq_tt | output | 9 | Selected trap type |
| wake | output | 1 | One-cycle pulse that clears the halted state |

## Verification
The wake pulse and a fresh request can both come from the same clock edge. The bench provokes this by raising an external line above `cur_pil` while interrupts are enabled, and expects `wake`, `irq_req` and the new `irq_tt` together one clock later.

The second coincidence is a timer-match flag and an external or software request for level 14 active at the same time. These must merge into a single level-14 candidate. The bench also lowers one of the two sources while the other stays active, and expects no change on the outputs.

Every vector is compared against a reference model computed in the bench, including long mixed pseudo-random runs in which the trap-level suppression and the disable also fall in these cycles.

// File: rtl/pil_pkg.sv
package pil_pkg;
   localparam int unsigned PIL_DEF_LEVELS  = 16;
   localparam int unsigned PIL_DEF_TT_W    = 9;
   localparam int unsigned PIL_DEF_TL_W    = 3;
   localparam int unsigned PIL_DEF_TMR_LVL = 14;
   localparam logic [PIL_DEF_TT_W-1:0] PIL_DEF_TT_BASE = 9'h040;
endpackage

// File: rtl/pil_pending_merge.sv
module pil_pending_merge #(
   parameter int unsigned NUM_LVL    = 16,
   parameter int unsigned TICK_BIT   = 0,
   parameter int unsigned TIMER_LVL  = 14,
   parameter bit          TIMER_FOLD = 1'b1
) (
   input  logic [NUM_LVL-1:0] ext_lvl,
   input  logic [NUM_LVL:0]   soft_int,
   output logic [NUM_LVL-1:0] pending
);
   localparam int unsigned STICK_BIT = NUM_LVL;

   logic [NUM_LVL-1:0] direct;
   logic [NUM_LVL-1:0] fold_vec;
   logic               timer_hit;

   assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_direct
      if (k == TICK_BIT) begin : g_tick
         assign direct[k] = 1'b0;
      end else begin : g_lvl
         assign direct[k] = soft_int[k];
      end
   end

   if (TIMER_FOLD) begin : g_fold
      assign fold_vec = timer_hit ? (NUM_LVL'(1) << TIMER_LVL) : '0;
   end else begin : g_nofold
      assign fold_vec = '0;
   end

   assign pending = ext_lvl | direct | fold_vec;
endmodule

// File: rtl/pil_priority_scan.sv
module pil_priority_scan #(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] pending,
   input  logic [LVL_W-1:0]   cur_pil,
   output logic               found,
   output logic [LVL_W-1:0]   win_lvl
);
   logic [NUM_LVL-1:0] elig;

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_elig
      if (k == 0) begin : g_zero
         assign elig[k] = 1'b0;
      end else begin : g_cmp
         assign elig[k] = pending[k] & (LVL_W'(k) > cur_pil);
      end
   end

   always_comb begin
      found   = 1'b0;
      win_lvl = '0;
      for (int k = 1; k < NUM_LVL; k++) begin
         if (elig[k]) begin
            found   = 1'b1;
            win_lvl = LVL_W'(k);
         end
      end
   end
endmodule

// File: rtl/pil_request_ctl.sv
module pil_request_ctl #(
   parameter int unsigned   LVL_W   = 4,
   parameter int unsigned   TT_W    = 9,
   parameter int unsigned   TL_W    = 3,
   parameter logic [TT_W-1:0] TT_BASE = 9'h040
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_pend,
   input  logic             int_en,
   input  logic             found,
   input  logic [LVL_W-1:0] win_lvl,
   input  logic [TL_W-1:0]  trap_lvl,
   input  logic [TT_W-1:0]  trap_tt_cur,
   output logic             irq_req,
   output logic [TT_W-1:0]  irq_tt
);
   logic [TT_W-1:0] cand;
   logic            blocked;
   logic            take;

   assign cand    = TT_BASE | TT_W'(win_lvl);
   assign blocked = (trap_lvl != '0) && (trap_tt_cur > cand);
   assign take    = int_en && found && !blocked && (cand != irq_tt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_tt  <= '0;
      end else if (!any_pend) begin
         irq_req <= 1'b0;
         irq_tt  <= '0;
      end else if (take) begin
         irq_req <= 1'b1;
         irq_tt  <= cand;
      end
   end

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !any_pend |=> (!irq_req && irq_tt == '0)); // R3
   AST_NESTED_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_pend && found && trap_lvl != '0 && trap_tt_cur > cand)
      |=> ($stable(irq_tt) && $stable(irq_req))); // R5
   AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_pend && !int_en) |=> ($stable(irq_tt) && $stable(irq_req))); // R7
   AST_RAISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(int_en)); // R4
endmodule

// File: rtl/pil_prioritizer.sv
module pil_prioritizer
   import pil_pkg::*;
#(
   parameter int unsigned     NUM_LVL    = PIL_DEF_LEVELS,
   parameter int unsigned     TT_W       = PIL_DEF_TT_W,
   parameter int unsigned     TL_W       = PIL_DEF_TL_W,
   parameter int unsigned     TIMER_LVL  = PIL_DEF_TMR_LVL,
   parameter bit              TIMER_FOLD = 1'b1,
   parameter logic [TT_W-1:0] TT_BASE    = PIL_DEF_TT_BASE,
   localparam int unsigned    LVL_W      = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] ext_lvl,
   input  logic [NUM_LVL:0]   soft_int,
   input  logic [LVL_W-1:0]   cur_pil,
   input  logic               int_en,
   input  logic [TL_W-1:0]    trap_lvl,
   input  logic [TT_W-1:0]    trap_tt_cur,
   output logic               irq_req,
   output logic [TT_W-1:0]    irq_tt,
   output logic               wake
);
   initial begin
      assert (NUM_LVL >= 2 && (1 << LVL_W) == NUM_LVL)
         else $error("level count must be a power of two");
      assert (TIMER_LVL > 0 && TIMER_LVL < NUM_LVL)
         else $error("timer level out of range");
      assert (TT_W > LVL_W && (TT_BASE & TT_W'(NUM_LVL - 1)) == '0)
         else $error("trap base overlaps level field");
   end

   logic [NUM_LVL-1:0] pending;
   logic               found;
   logic [LVL_W-1:0]   win_lvl;
   logic [NUM_LVL-1:0] ext_q;

   pil_pending_merge #(
      .NUM_LVL(NUM_LVL), .TICK_BIT(0), .TIMER_LVL(TIMER_LVL), .TIMER_FOLD(TIMER_FOLD)
   ) u_merge (
      .ext_lvl(ext_lvl), .soft_int(soft_int), .pending(pending)
   );

   pil_priority_scan #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_scan (
      .pending(pending), .cur_pil(cur_pil), .found(found), .win_lvl(win_lvl)
   );

   pil_request_ctl #(
      .LVL_W(LVL_W), .TT_W(TT_W), .TL_W(TL_W), .TT_BASE(TT_BASE)
   ) u_req (
      .clk(clk), .rst_n(rst_n), .any_pend(|pending), .int_en(int_en),
      .found(found), .win_lvl(win_lvl), .trap_lvl(trap_lvl),
      .trap_tt_cur(trap_tt_cur), .irq_req(irq_req), .irq_tt(irq_tt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= '0;
         wake  <= 1'b0;
      end else begin
         ext_q <= ext_lvl;
         wake  <= |(ext_lvl & ~ext_q);
      end
   end

   AST_WAKE_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(|ext_lvl)); // R8
endmodule

// File: tb/sim_pil_prioritizer.sv
module sim_pil_prioritizer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_lvl = '0;
   logic [16:0] soft_int = '0;
   logic [3:0]  cur_pil = '0;
   logic        int_en = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  trap_tt_cur = '0;
   logic        irq_req;
   logic [8:0]  irq_tt;
   logic        wake;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic        m_req = 1'b0;
   logic [8:0]  m_tt = '0;
   logic [15:0] m_prev = '0;
   logic [31:0] seed = 32'h1234_5677;

   always #4 clk = ~clk;

   pil_prioritizer u0 (
      .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
      .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl),
      .trap_tt_cur(trap_tt_cur), .irq_req(irq_req), .irq_tt(irq_tt), .wake(wake)
   );

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] v = s;
      v = v ^ (v << 13);
      v = v ^ (v >> 17);
      v = v ^ (v << 5);
      return v;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic compare(input string tag, input logic e_req, input logic [8:0] e_tt,
                          input logic e_wake);
      n_vec++;
      if (irq_req !== e_req || irq_tt !== e_tt || wake !== e_wake) begin
         n_bad++;
         $display("FAIL %s: req/tt/wake actual %0b/%h/%0b expected %0b/%h/%0b",
                  tag, irq_req, irq_tt, wake, e_req, e_tt, e_wake);
      end
   endtask

   // Drive one input vector and check the registered result one clock later
   task automatic apply(input string tag, input logic [15:0] e, input logic [16:0] s,
                        input logic [3:0] pil, input logic en, input logic [2:0] tl,
                        input logic [8:0] ctt);
      logic [15:0] p;
      logic [8:0]  cand;
      logic        hit;
      logic        e_wake;
      ext_lvl = e; soft_int = s; cur_pil = pil; int_en = en;
      trap_lvl = tl; trap_tt_cur = ctt;
      p = e | (s[15:0] & 16'hFFFE);
      if (s[0] || s[16]) p[14] = 1'b1;
      e_wake = |(e & ~m_prev);
      m_prev = e;
      hit = 1'b0; cand = '0;
      for (int i = 15; i >= 1; i--)
         if (!hit && p[i] && i > int'(pil)) begin
            hit = 1'b1;
            cand = 9'h040 + 9'(i);
         end
      if (p == '0) begin
         m_req = 1'b0; m_tt = '0;
      end else if (en && hit && !(tl != 0 && ctt > cand) && cand != m_tt) begin
         m_req = 1'b1; m_tt = cand;
      end
      @(posedge clk);
      #2;
      compare(tag, m_req, m_tt, e_wake);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      compare("R9 reset", 1'b0, 9'h000, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R4 / R3: single external level against every interrupt level
      for (int pil = 0; pil < 16; pil++)
         for (int l = 0; l < 16; l++) begin
            apply("R4", 16'(1) << l, '0, 4'(pil), 1'b1, 3'd0, 9'h0);
            apply("R3", '0, '0, 4'(pil), 1'b1, 3'd0, 9'h0);
         end

      // R1 / R2: each software bit alone
      for (int b = 0; b < 17; b++)
         for (int pil = 0; pil < 16; pil++) begin
            apply((b == 0 || b == 16) ? "R2" : "R1", '0, 17'(1) << b, 4'(pil),
                  1'b1, 3'd0, 9'h0);
            apply("R3", '0, '0, 4'(pil), 1'b1, 3'd0, 9'h0);
         end

      // R2: timer fold together with a direct level-14 source, then one dropped
      apply("R2", 16'h4000, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0);
      apply("R2", 16'h0000, 17'h10001, 4'd0, 1'b1, 3'd0, 9'h0);
      apply("R2", 16'h0000, 17'h04000, 4'd0, 1'b1, 3'd0, 9'h0);
      apply("R3", '0, '0, 4'd0, 1'b1, 3'd0, 9'h0);

      // R5: nested trap comparison sweep
      for (int tl = 0; tl < 8; tl += 3)
         for (int c = 9'h03C; c < 9'h053; c++)
            for (int l = 1; l < 16; l += 2) begin
               apply("R5", 16'(1) << l, '0, 4'd0, 1'b1, 3'(tl), 9'(c));
               apply("R5", 16'(1) << (l + 1 > 15 ? 15 : l + 1), '0, 4'd0, 1'b1,
                     3'(tl), 9'(c));
               apply("R3", '0, '0, 4'd0, 1'b1, 3'(tl), 9'(c));
            end

      // R6: pending only at or below the interrupt level
      apply("R6", 16'h0200, '0, 4'd0, 1'b1, 3'd0, 9'h0);
      apply("R6", 16'h0008, '0, 4'd10, 1'b1, 3'd0, 9'h0);
      apply("R6", 16'h0001, '0, 4'd0, 1'b1, 3'd0, 9'h0);
      apply("R6", 16'h0009, '0, 4'd3, 1'b1, 3'd0, 9'h0);

      // R7: globally disabled
      for (int l = 1; l < 16; l++) begin
         apply("R7", 16'h0020, '0, 4'd0, 1'b1, 3'd0, 9'h0);
         apply("R7", 16'h0020 | (16'(1) << l), '0, 4'd0, 1'b0, 3'd0, 9'h0);
         apply("R7", 16'(1) << l, '0, 4'd0, 1'b0, 3'd0, 9'h0);
         apply("R3", '0, '0, 4'd0, 1'b0, 3'd0, 9'h0);
      end

      // R8: rises, falls and software-only changes
      for (int l = 0; l < 16; l++) begin
         apply("R8", 16'(1) << l, '0, 4'd0, 1'b1, 3'd0, 9'h0);
         apply("R8", (16'(1) << l) | 16'h0001, '0, 4'd0, 1'b1, 3'd0, 9'h0);
         apply("R8", 16'h0001, 17'(1) << l, 4'd0, 1'b1, 3'd0, 9'h0);
         apply("R8", 16'h0000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0);
      end

      // Mixed pseudo-random run over all inputs
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] a;
         logic [31:0] b;
         seed = nxt(seed); a = seed;
         seed = nxt(seed); b = seed;
         apply("R4/R5/R7", a[15:0] & a[31:16], {b[16], b[15:0] & b[31:16]},
               b[20:17], b[23:21] != 3'd0, (b[24] ? b[27:25] : 3'd0),
               9'h03C + 9'(b[31:28]) + 9'(a[3:0]));
      end

      rst_n = 1'b0;
      #2;
      compare("R9 reset", 1'b0, 9'h000, 1'b0);
      finish_run();
   end
endmodule